// File: doc/BRIEF.md
# Indexed Block Register Target for SMBus

This block is an SMBus target that holds a nine-entry bank of byte-wide configuration registers. A host writes a run of registers by sending a starting index, a byte count and then the data. It reads a run by sending the index, issuing a repeated START with the read bit, and then clocking out a length byte followed by register contents. The length byte comes from a writable count register. After each byte the index advances by one.

The 7-bit target address is chosen by two three-level straps. The straps arrive already reduced to low, mid and high codes, so they give nine possible addresses. SCL and SDA are sampled on the system clock through synchronizers with glitch filters. SDA is driven only as an open-drain enable. The whole register view is presented as a flat vector for downstream control logic. A 4-bit revision value enters from outside and appears in a read-only register.

Top module: `smb_idx_regs`

## Requirements
- R1: After reset, register 7 reads 08 hex, registers 0 to 4 and 8 read 00, and the SDA enable is low.
- R2: The straps use code 0 for low, 1 for mid and 2 or 3 for high. The pair (A1, A0) selects the 8-bit write address as follows: LL D8, LM DA, LH DE, ML C2, MM C4, MH C6, HL CA, HM CC, HH CE. The target ACKs a matching address, where ACK means SDA is driven low in the ninth clock.
- R3: A non-matching address is NACKed. All later bytes are then ignored and NACKed until the next START or STOP.
- R4: In a write transfer (address with bit 0 = 0, index N, count X, data), each data byte is stored at the current index and ACKed, and the index then advances by one.
- R5: Data bytes sent after X bytes have been accepted are NACKed and not stored.
- R6: In a read transfer (address write, index N, repeated START, address with bit 0 = 1), the target first sends register 7 and then registers N, N+1 and so on, MSB first. It stops and releases SDA on a host NACK.
- R7: Registers 0 to 3 are fully writable and register 7 bits 4:0 are writable. All other bits are ACKed on write but keep their value, and register 7 bits 7:5 read 0.
- R8: Register 5 reads {rev_id_i, 4'b0001} and register 6 reads C3 hex.
- R9: An index of 9 or above reads as 00, and writes to it change nothing.
- R10: SDA enable changes only while filtered SCL is low, and it is low in the cycle after any START or STOP.
- R11: A pulse on SCL or SDA shorter than FILT_CYC system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pin |
| sda_i | input | 1 | SMBus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a1_i | input | 2 | Upper address strap level code |
| strap_a0_i | input | 2 | Lower address strap level code |
| rev_id_i | input | 4 | Revision value shown in register 5 |
| cfg_o | output | 72 | Register view, register i at bits 8i+7:8i |

## Verification
Four properties are checked on every cycle. SDA moves only while the filtered clock is low, SDA is released after each START and STOP, every stored byte coincides with an ACK being driven, and the writable registers change only right after a write strobe. Address selection, NACK-and-ignore behaviour, byte-count limits, read ordering and the length byte, masking of read-only bits, out-of-range indices and glitch rejection all depend on multi-byte bus sequences, so only the bench scenarios can show them.

// File: rtl/smb_idx_pkg.sv
// Shared constants, types and register-map helper functions for the
// indexed SMBus register target. Assumes a fixed nine-entry map.
package smb_idx_pkg;

    localparam int NUM_REG  = 9;
    localparam int IDX_W    = 8;
    localparam int REG_CNT  = 7;
    localparam int REG_REV  = 5;
    localparam int REG_DEV  = 6;
    localparam logic [7:0] DEV_CODE    = 8'hC3;
    localparam logic [3:0] VENDOR_CODE = 4'h1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    typedef enum logic [1:0] {
        RB_ADDR,
        RB_INDEX,
        RB_COUNT,
        RB_DATA
    } rx_role_t;

    // Bits a bus write may change in register i.
    function automatic logic [7:0] reg_wmask(input int i);
        if (i < 4)        return 8'hFF;
        if (i == REG_CNT) return 8'h1F;
        return 8'h00;
    endfunction

    // Value register i takes on reset.
    function automatic logic [7:0] reg_rstval(input int i);
        return (i == REG_CNT) ? 8'h08 : 8'h00;
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
// Two-flop synchronizer followed by a persistence filter: the output follows
// the synchronized input only after it has held a new level for FILT_CYC
// consecutive clocks. Assumes the line idles high.
module smb_line_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Synchronize the pin and accept a new level only once it is persistent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
                line_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smb_addr_decode.sv
// Maps two pre-decoded three-level strap codes (0 low, 1 mid, 2/3 high) to
// the 7-bit target address. Purely combinational; straps assumed static.
module smb_addr_decode (
    input  logic [1:0] strap_a1_i,
    input  logic [1:0] strap_a0_i,
    output logic [6:0] addr7_o
);
    // Fold the four-valued code onto three levels.
    function automatic logic [1:0] level(input logic [1:0] code);
        if (code == 2'd0) return 2'd0;
        if (code == 2'd1) return 2'd1;
        return 2'd2;
    endfunction

    // Select one of nine addresses from the level pair.
    always_comb begin
        case ({level(strap_a1_i), level(strap_a0_i)})
            4'b0000: addr7_o = 7'h6C;
            4'b0001: addr7_o = 7'h6D;
            4'b0010: addr7_o = 7'h6F;
            4'b0100: addr7_o = 7'h61;
            4'b0101: addr7_o = 7'h62;
            4'b0110: addr7_o = 7'h63;
            4'b1000: addr7_o = 7'h65;
            4'b1001: addr7_o = 7'h66;
            4'b1010: addr7_o = 7'h67;
            default: addr7_o = 7'h6C;
        endcase
    end
endmodule

// File: rtl/smb_reg_bank.sv
// Register map: writable storage only where the write mask is non-zero,
// constants for identity registers, zero for reserved ones. One write port,
// one combinational read port; out-of-range indices read zero.
module smb_reg_bank
    import smb_idx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [3:0]         rev_id_i,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic [NUM_REG*8-1:0] cfg_o
);
    logic [7:0] view [NUM_REG];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        localparam logic [7:0] WM = reg_wmask(g);
        if (g == REG_REV) begin : g_rev
            assign view[g] = {rev_id_i, VENDOR_CODE};
        end else if (g == REG_DEV) begin : g_dev
            assign view[g] = DEV_CODE;
        end else if (WM == 8'h00) begin : g_rsvd
            assign view[g] = 8'h00;
        end else begin : g_store
            logic [7:0] q;
            // Merge writable bits of the incoming byte into the held value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= reg_rstval(g);
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= (wr_data & WM) | (q & ~WM);
            end
            assign view[g] = q;
        end
        assign cfg_o[8*g +: 8] = view[g];
    end

    // Select the register addressed by the read index.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = view[i];
    end
endmodule

// File: rtl/smb_idx_regs.sv
// SMBus target with indexed block write and block read. Filters the bus
// lines, detects START/STOP and SCL edges, and runs a byte-level state
// machine that ACKs, stores and returns register bytes. Assumes the system
// clock is many times the SCL rate and no clock stretching is needed.
module smb_idx_regs
    import smb_idx_pkg::*;
#(
    parameter int FILT_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic [1:0]           strap_a1_i,
    input  logic [1:0]           strap_a0_i,
    input  logic [3:0]           rev_id_i,
    output logic [NUM_REG*8-1:0] cfg_o
);
    logic scl_f, sda_f, scl_q, sda_q;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] addr7;

    bus_state_t       state;
    rx_role_t         role;
    logic [2:0]       bitcnt;
    logic             rx_full, ack_q, rd_mode, host_ack;
    logic [7:0]       shreg, txsh, remain;
    logic [IDX_W-1:0] idx, wr_idx;
    logic [7:0]       wr_data, rd_data, cnt_byte;
    logic             wr_en, byte_ack;

    smb_line_filter #(.FILT_CYC(FILT_CYC)) scl_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    smb_line_filter #(.FILT_CYC(FILT_CYC)) sda_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    smb_addr_decode addr_i (
        .strap_a1_i(strap_a1_i), .strap_a0_i(strap_a0_i), .addr7_o(addr7));

    smb_reg_bank bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rev_id_i(rev_id_i), .rd_idx(idx),
        .rd_data(rd_data), .cfg_o(cfg_o));

    assign cnt_byte  = cfg_o[REG_CNT*8 +: 8];
    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decide whether the byte just received is to be acknowledged.
    always_comb begin
        case (role)
            RB_ADDR: byte_ack = (shreg[7:1] == addr7);
            RB_DATA: byte_ack = (remain != 8'd0);
            default: byte_ack = 1'b1;
        endcase
    end

    // Byte-level transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            role     <= RB_ADDR;
            bitcnt   <= '0;
            rx_full  <= 1'b0;
            ack_q    <= 1'b0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            shreg    <= '0;
            txsh     <= '0;
            remain   <= '0;
            idx      <= '0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_en    <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_RX;
                role     <= RB_ADDR;
                bitcnt   <= '0;
                rx_full  <= 1'b0;
                rd_mode  <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) rx_full <= 1'b1;
                        end else if (scl_fall && rx_full) begin
                            rx_full  <= 1'b0;
                            state    <= ST_RX_ACK;
                            sda_oe_o <= byte_ack;
                            ack_q    <= byte_ack;
                            case (role)
                                RB_ADDR: if (byte_ack) begin
                                    rd_mode <= shreg[0];
                                    role    <= RB_INDEX;
                                end
                                RB_INDEX: begin
                                    idx  <= shreg;
                                    role <= RB_COUNT;
                                end
                                RB_COUNT: begin
                                    remain <= shreg;
                                    role   <= RB_DATA;
                                end
                                default: if (byte_ack) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= shreg;
                                    idx     <= idx + 1'b1;
                                    remain  <= remain - 8'd1;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (!ack_q) begin
                                state    <= ST_IDLE;
                                sda_oe_o <= 1'b0;
                            end else if (rd_mode && role == RB_INDEX) begin
                                txsh     <= cnt_byte;
                                sda_oe_o <= ~cnt_byte[7];
                                state    <= ST_TX;
                            end else begin
                                state    <= ST_RX;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                state    <= ST_TX_ACK;
                                sda_oe_o <= 1'b0;
                            end else begin
                                txsh     <= {txsh[6:0], 1'b0};
                                bitcnt   <= bitcnt + 3'd1;
                                sda_oe_o <= ~txsh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                txsh     <= rd_data;
                                idx      <= idx + 1'b1;
                                bitcnt   <= '0;
                                sda_oe_o <= ~rd_data[7];
                                state    <= ST_TX;
                            end else begin
                                state    <= ST_IDLE;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_idx_regs_chk.sv
// Cycle-level properties of the register target, bound onto its top module.
module smb_idx_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_f,
    input logic        start_det,
    input logic        stop_det,
    input logic        wr_en,
    input logic        sda_oe,
    input logic [39:0] cfg_wr
);
    // R10: data line moves only while the filtered clock is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R10: released after START
    a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R10: released after STOP
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: a stored byte is always being acknowledged
    a_r4_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    // R7: writable registers change only after a write strobe
    a_r7_change_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_wr) |-> $past(wr_en));
endmodule

bind smb_idx_regs smb_idx_regs_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .sda_oe   (sda_oe_o),
    .cfg_wr   ({cfg_o[63:56], cfg_o[31:0]})
);

// File: tb/smb_idx_regs_tb_top.sv
// Scoreboard bench: bus driver tasks queue expected bytes and ACK bits,
// a monitor pops and compares them against what the bus produced.
module smb_idx_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic [1:0]  strap_a1 = 2'd0;
    logic [1:0]  strap_a0 = 2'd0;
    logic [3:0]  rev_id = 4'h1;
    logic        sda_oe;
    logic [71:0] cfg;
    logic        sda_line;
    logic [7:0]  waddr = 8'hD8;
    logic [71:0] snap;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_v[$];
    string      exp_tag[$];
    logic [7:0] obs_v[$];

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_idx_regs dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_a1_i(strap_a1), .strap_a0_i(strap_a0),
        .rev_id_i(rev_id), .cfg_o(cfg));

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare produced bus items with expected ones in order.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_v.size() > 0 && exp_v.size() > 0) begin
                logic [7:0] e;
                logic [7:0] o;
                string t;
                e = exp_v.pop_front();
                t = exp_tag.pop_front();
                o = obs_v.pop_front();
                check(t, {64'd0, o}, {64'd0, e});
            end
        end
    end

    task automatic qw;
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; qw;
        scl_drv = 1'b1; qw;
        sda_drv = 1'b0; qw;
        scl_drv = 1'b0; qw;
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; qw;
        scl_drv = 1'b1; qw;
        sda_drv = 1'b1; qw;
    endtask

    task automatic put_bit(input logic b, input logic glitch);
        sda_drv = b; qw;
        scl_drv = 1'b1; qw;
        if (glitch) begin
            scl_drv = 1'b0;
            @(negedge clk);
            scl_drv = 1'b1;
        end
        qw;
        scl_drv = 1'b0; qw;
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; qw;
        scl_drv = 1'b1; qw;
        b = sda_line; qw;
        scl_drv = 1'b0; qw;
    endtask

    // Send one byte; expect ACK bit exp_ack (0 = ACK).
    task automatic wr_byte(input logic [7:0] v, input logic exp_ack,
                           input string tag, input logic glitch);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(a);
        exp_v.push_back({7'd0, exp_ack});
        exp_tag.push_back({tag, " ack"});
        obs_v.push_back({7'd0, a});
    endtask

    // Receive one byte and answer with ACK, or NACK when last.
    task automatic rd_byte(input logic [7:0] exp, input logic last, input string tag);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(last, 1'b0);
        exp_v.push_back(exp);
        exp_tag.push_back({tag, " data"});
        obs_v.push_back(v);
    endtask

    task automatic wr_txn(input logic [7:0] idx, input logic [7:0] cnt, input int nsend,
                          input logic [7:0] d [6], input string tag, input logic glitch);
        bus_start;
        wr_byte(waddr, 1'b0, tag, glitch);
        wr_byte(idx, 1'b0, tag, glitch);
        wr_byte(cnt, 1'b0, tag, glitch);
        for (int i = 0; i < nsend; i++)
            wr_byte(d[i], (i < int'(cnt)) ? 1'b0 : 1'b1, tag, glitch);
        bus_stop;
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int nread,
                          input logic [7:0] e [6], input string tag);
        bus_start;
        wr_byte(waddr, 1'b0, tag, 1'b0);
        wr_byte(idx, 1'b0, tag, 1'b0);
        bus_start;
        wr_byte(waddr | 8'h01, 1'b0, tag, 1'b0);
        for (int i = 0; i < nread; i++) rd_byte(e[i], (i == nread - 1), tag);
        bus_stop;
    endtask

    task automatic finish_run;
        repeat (20) @(negedge clk);
        if (exp_v.size() != 0) check("scoreboard drain", 72'(obs_v.size()), 72'(exp_v.size()));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] tbl [9];
        tbl = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state, R8 identity registers
        for (int i = 0; i < 5; i++) check("R1 reg0-4", {64'd0, cfg[8*i +: 8]}, 72'h00);
        check("R1 reg8", {64'd0, cfg[71:64]}, 72'h00);
        check("R1 count reg", {64'd0, cfg[63:56]}, 72'h08);
        check("R1 sda released", {71'd0, sda_oe}, 72'd0);
        check("R8 rev reg", {64'd0, cfg[47:40]}, 72'h11);
        check("R8 device reg", {64'd0, cfg[55:48]}, 72'hC3);

        // R2 every strap combination selects its address
        for (int h = 0; h < 3; h++) begin
            for (int l = 0; l < 3; l++) begin
                strap_a1 = 2'(h);
                strap_a0 = 2'(l);
                waddr = tbl[h*3 + l];
                bus_start;
                wr_byte(waddr, 1'b0, "R2 address", 1'b0);
                bus_stop;
            end
        end
        strap_a1 = 2'd3; strap_a0 = 2'd3;
        waddr = 8'hCE;
        bus_start; wr_byte(waddr, 1'b0, "R2 code3 high", 1'b0); bus_stop;
        strap_a1 = 2'd0; strap_a0 = 2'd0;
        waddr = 8'hD8;

        // R3 mismatch NACKed, then ignored until STOP
        bus_start;
        wr_byte(8'hDA, 1'b1, "R3 mismatch", 1'b0);
        wr_byte(8'hD8, 1'b1, "R3 ignored", 1'b0);
        bus_stop;
        check("R3 regs untouched", {40'd0, cfg[31:0]}, 72'd0);

        // R4 block write with auto-increment
        wr_txn(8'd0, 8'd4, 4, '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h00, 8'h00}, "R4", 1'b0);
        check("R4 regs0-3", {40'd0, cfg[31:0]}, 72'hD4C3B2A1);
        check("R10 released after stop", {71'd0, sda_oe}, 72'd0);

        // R5 bytes beyond the count are NACKed and dropped
        wr_txn(8'd1, 8'd1, 2, '{8'h55, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00}, "R5", 1'b0);
        check("R5 reg1", {64'd0, cfg[15:8]}, 72'h55);
        check("R5 reg2 kept", {64'd0, cfg[23:16]}, 72'hC3);

        // R7 read-only and reserved bits keep their values
        wr_txn(8'd4, 8'd5, 5, '{8'hFF, 8'hFF, 8'hFF, 8'hE3, 8'hFF, 8'h00}, "R7", 1'b0);
        check("R7 reg4", {64'd0, cfg[39:32]}, 72'h00);
        check("R7 reg5", {64'd0, cfg[47:40]}, 72'h11);
        check("R7 reg6", {64'd0, cfg[55:48]}, 72'hC3);
        check("R7 count masked", {64'd0, cfg[63:56]}, 72'h03);
        check("R7 reg8", {64'd0, cfg[71:64]}, 72'h00);

        // R6 block read: count byte first, then N onward
        rd_txn(8'd1, 4, '{8'h03, 8'h55, 8'hC3, 8'hD4, 8'h00, 8'h00}, "R6");
        check("R6 released after NACK", {71'd0, sda_oe}, 72'd0);

        // R9 index past the map
        rd_txn(8'd7, 4, '{8'h03, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00}, "R9 read");
        snap = cfg;
        wr_txn(8'd9, 8'd1, 1, '{8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R9 write", 1'b0);
        check("R9 map unchanged", cfg, snap);

        // R8 revision input reflected in register 5
        rev_id = 4'hA;
        repeat (2) @(negedge clk);
        check("R8 rev follows input", {64'd0, cfg[47:40]}, 72'hA1);
        rd_txn(8'd5, 3, '{8'h03, 8'hA1, 8'hC3, 8'h00, 8'h00, 8'h00}, "R8 read");

        // R11 short SCL glitches inside every bit are rejected
        wr_txn(8'd0, 8'd1, 1, '{8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R11", 1'b1);
        check("R11 reg0", {64'd0, cfg[7:0]}, 72'h5A);

        finish_run;
    end
endmodule